// File: doc/BRIEF.md
# Average Current and Time-to-Empty Engine

This block turns a stream of signed current-sense samples into two host-readable values. Each strobed sample contributes its magnitude to a block window of 256 samples. With samples arriving at 50 Hz, one window spans 5.12 s. When a window closes, the mean magnitude is published as a 16-bit value, split into a high byte and a low byte. The accumulator then clears and the next window starts.

Each window close starts a time-to-empty computation. The block captures the compensated capacity input and the new average current. It forms sixty times the capacity with two shifts and a subtraction, then divides by the average with a restoring divider that takes 16 cycles. The quotient is the time in minutes. It is written to the output pair in one step, with a single-cycle valid strobe.

A zero average current, or a quotient that does not fit in 16 bits, skips the divider and saturates the result to 0xFFFF. The control FSM has three states:
- `ST_IDLE` waits for a window close. On a close it latches the operands and takes the transition *start* to `ST_SCALE`.
- `ST_SCALE` forms the scaled dividend and tests for saturation. It takes either *saturate* back to `ST_IDLE`, writing 0xFFFF, or *launch* to `ST_DIVIDE`.
- `ST_DIVIDE` waits for the divider. It takes *commit* back to `ST_IDLE` and writes the quotient.

Top module: `tte_avg_current`

## Requirements
- R1: After reset, the average current reads 0, time-to-empty reads 0xFFFF, and busy and valid are both 0.
- R2: The published average is floor(sum of |sample| over the 256 strobed samples of a window / 256). The sign of each sample is discarded, so -32768 contributes 32768.
- R3: The average changes only on the clock edge that takes the 256th strobed sample of a window. The next window then starts from an empty sum, and a sample presented with the strobe low has no effect.
- R4: The average current reads as 256 × `iavg_hi` + `iavg_lo`.
- R5: When the average A is nonzero and floor(60 × C / A) ≤ 65535, time-to-empty equals floor(60 × C / A). Here C is the capacity input sampled one cycle after the window close.
- R6: When the average is 0, time-to-empty is written as 0xFFFF.
- R7: When floor(60 × C / A) exceeds 65535, time-to-empty is written as 0xFFFF.
- R8: Busy rises one cycle after the window-close edge. For a saturated result, valid pulses for one cycle 2 cycles after that edge. For a divided result, valid pulses 19 cycles after that edge. Busy falls in the same cycle that valid rises.
- R9: Time-to-empty changes only in a cycle in which valid is high, and valid never stays high for two consecutive cycles.
- R10: Time-to-empty reads as 256 × `tte_hi` + `tte_lo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Marks `smp_cur` as a valid sample this cycle |
| smp_cur | input | 16 | Signed current-sense sample |
| cap_comp | input | 16 | Compensated available capacity |
| iavg_hi | output | 8 | Average current, high byte |
| iavg_lo | output | 8 | Average current, low byte |
| tte_hi | output | 8 | Time-to-empty in minutes, high byte |
| tte_lo | output | 8 | Time-to-empty in minutes, low byte |
| tte_busy | output | 1 | A time-to-empty computation is in progress |
| tte_valid | output | 1 | One-cycle pulse when time-to-empty is updated |

## Verification
Windows of constant positive samples and constant negative samples at the same magnitude show whether the sign is really discarded. An alternating positive/negative window and a ramp window whose mean has a fraction show whether sums and truncation are correct. The -32768 window probes the one magnitude that needs the top bit. Windows averaging 60 and 59 against a full-scale capacity sit exactly on either side of the overflow limit, and so separate a divided 0xFFFF from a saturated one. The two cases are also told apart by their latency. Zero-sample and zero-capacity windows cover the other two edges of the division. Gapped strobes carrying junk samples show whether unstrobed inputs are ignored.

// File: rtl/tte_pkg.sv
package tte_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCALE  = 2'd1,
        ST_DIVIDE = 2'd2
    } tte_state_e;

    // 60*x is built as (x << MUL_SH_HI) - (x << MUL_SH_LO)
    localparam int MUL_SH_HI = 6;
    localparam int MUL_SH_LO = 2;

endpackage

// File: rtl/iavg_window.sv
module iavg_window #(
    parameter int SMP_W    = 16,
    parameter int WIN_LOG2 = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_stb,
    input  logic signed [SMP_W-1:0] smp_cur,
    output logic [SMP_W-1:0]        avg_out,
    output logic                    win_done
);
    localparam int ACC_W = SMP_W + WIN_LOG2;

    logic [SMP_W-1:0]    mag;
    logic [ACC_W-1:0]    acc_q;
    logic [ACC_W-1:0]    acc_sum;
    logic [WIN_LOG2-1:0] cnt_q;
    logic                win_last;

    // Magnitude; the most negative code maps to 2^(SMP_W-1), which still fits
    always_comb begin
        if (smp_cur[SMP_W-1]) begin
            mag = $unsigned(-smp_cur);
        end else begin
            mag = $unsigned(smp_cur);
        end
        acc_sum  = acc_q + ACC_W'(mag);
        win_last = &cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            avg_out  <= '0;
            win_done <= 1'b0;
        end else begin
            win_done <= 1'b0;
            if (smp_stb) begin
                cnt_q <= cnt_q + 1'b1;
                if (win_last) begin
                    avg_out  <= acc_sum[ACC_W-1:WIN_LOG2];
                    acc_q    <= '0;
                    win_done <= 1'b1;
                end else begin
                    acc_q <= acc_sum;
                end
            end
        end
    end

endmodule

// File: rtl/tte_scale.sv
module tte_scale #(
    parameter int CAP_W = 16,
    parameter int DEN_W = 16,
    parameter int Q_W   = 16
) (
    input  logic [CAP_W-1:0]                     cap,
    input  logic [DEN_W-1:0]                     den,
    output logic [CAP_W+tte_pkg::MUL_SH_HI-Q_W-1:0] num_hi,
    output logic [Q_W-1:0]                       num_lo,
    output logic                                 sat
);
    localparam int NUM_W = CAP_W + tte_pkg::MUL_SH_HI;
    localparam int RH_W  = NUM_W - Q_W;

    logic [NUM_W-1:0] num;
    logic [DEN_W-1:0] hi_ext;

    always_comb begin
        num    = (NUM_W'(cap) << tte_pkg::MUL_SH_HI) - (NUM_W'(cap) << tte_pkg::MUL_SH_LO);
        num_hi = num[NUM_W-1:Q_W];
        num_lo = num[Q_W-1:0];
        hi_ext = DEN_W'(num_hi);
        // Quotient fits in Q_W bits only if the upper dividend part is below the divisor
        sat    = (den == '0) || (hi_ext >= den);
    end

    if (RH_W > DEN_W) begin : g_bad_width
        initial $error("tte_scale: upper dividend wider than divisor");
    end

endmodule

// File: rtl/tte_divider.sv
module tte_divider #(
    parameter int DEN_W = 16,
    parameter int Q_W   = 16,
    parameter int RH_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [RH_W-1:0]  num_hi,
    input  logic [Q_W-1:0]   num_lo,
    input  logic [DEN_W-1:0] den,
    output logic [Q_W-1:0]   quo,
    output logic             done
);
    localparam int CNT_W = $clog2(Q_W + 1);

    logic [DEN_W-1:0] rem_q;
    logic [Q_W-1:0]   dvd_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DEN_W:0]   rem_sh;
    logic [DEN_W:0]   rem_diff;
    logic             take;

    always_comb begin
        rem_sh   = {rem_q, dvd_q[Q_W-1]};
        rem_diff = rem_sh - {1'b0, den};
        take     = (rem_sh >= {1'b0, den});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            dvd_q <= '0;
            quo   <= '0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q <= DEN_W'(num_hi);
                dvd_q <= num_lo;
                quo   <= '0;
                cnt_q <= CNT_W'(Q_W);
            end else if (cnt_q != '0) begin
                rem_q <= take ? rem_diff[DEN_W-1:0] : rem_sh[DEN_W-1:0];
                dvd_q <= {dvd_q[Q_W-2:0], 1'b0};
                quo   <= {quo[Q_W-2:0], take};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tte_avg_current.sv
module tte_avg_current #(
    parameter int SMP_W    = 16,
    parameter int WIN_LOG2 = 8,
    parameter int CAP_W    = 16,
    parameter int TTE_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_stb,
    input  logic signed [SMP_W-1:0] smp_cur,
    input  logic [CAP_W-1:0]        cap_comp,
    output logic [SMP_W-9:0]        iavg_hi,
    output logic [7:0]              iavg_lo,
    output logic [TTE_W-9:0]        tte_hi,
    output logic [7:0]              tte_lo,
    output logic                    tte_busy,
    output logic                    tte_valid
);
    import tte_pkg::*;

    localparam int AVG_W = SMP_W;
    localparam int NUM_W = CAP_W + MUL_SH_HI;
    localparam int RH_W  = NUM_W - TTE_W;

    tte_state_e state_q, state_d;

    logic [AVG_W-1:0] avg;
    logic             win_done;
    logic [CAP_W-1:0] cap_q;
    logic [AVG_W-1:0] den_q;
    logic [RH_W-1:0]  num_hi;
    logic [TTE_W-1:0] num_lo;
    logic             sat;
    logic             div_start;
    logic             div_done;
    logic [TTE_W-1:0] div_quo;
    logic [TTE_W-1:0] tte_q;
    logic             valid_q;

    iavg_window #(.SMP_W(SMP_W), .WIN_LOG2(WIN_LOG2)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_stb  (smp_stb),
        .smp_cur  (smp_cur),
        .avg_out  (avg),
        .win_done (win_done)
    );

    tte_scale #(.CAP_W(CAP_W), .DEN_W(AVG_W), .Q_W(TTE_W)) u_scale (
        .cap    (cap_q),
        .den    (den_q),
        .num_hi (num_hi),
        .num_lo (num_lo),
        .sat    (sat)
    );

    tte_divider #(.DEN_W(AVG_W), .Q_W(TTE_W), .RH_W(RH_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (div_start),
        .num_hi (num_hi),
        .num_lo (num_lo),
        .den    (den_q),
        .quo    (div_quo),
        .done   (div_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: start, saturate, launch, commit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (win_done) state_d = ST_SCALE;
            ST_SCALE:  state_d = sat ? ST_IDLE : ST_DIVIDE;
            ST_DIVIDE: if (div_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign div_start = (state_q == ST_SCALE) && !sat;

    // Outputs and operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q   <= '0;
            den_q   <= '0;
            tte_q   <= '1;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (win_done) begin
                        cap_q <= cap_comp;
                        den_q <= avg;
                    end
                end
                ST_SCALE: begin
                    if (sat) begin
                        tte_q   <= '1;
                        valid_q <= 1'b1;
                    end
                end
                ST_DIVIDE: begin
                    if (div_done) begin
                        tte_q   <= div_quo;
                        valid_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign iavg_hi   = avg[AVG_W-1:8];
    assign iavg_lo   = avg[7:0];
    assign tte_hi    = tte_q[TTE_W-1:8];
    assign tte_lo    = tte_q[7:0];
    assign tte_busy  = (state_q != ST_IDLE);
    assign tte_valid = valid_q;

endmodule

// File: rtl/tte_avg_current_chk.sv
module tte_avg_current_chk #(
    parameter int SMP_W = 16,
    parameter int TTE_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_stb,
    input logic [SMP_W-9:0] iavg_hi,
    input logic [7:0]       iavg_lo,
    input logic [TTE_W-9:0] tte_hi,
    input logic [7:0]       tte_lo,
    input logic             tte_busy,
    input logic             tte_valid
);
    logic [SMP_W-1:0] iavg;
    logic [TTE_W-1:0] tte;
    assign iavg = {iavg_hi, iavg_lo};
    assign tte  = {tte_hi, tte_lo};

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tte_valid |=> !tte_valid) else $error("valid held"); // R9

    AST_TTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tte_valid |-> $stable(tte)) else $error("tte moved without valid"); // R9

    AST_BUSY_ENDS_AT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tte_valid) |-> ($past(tte_busy) && !tte_busy)) else $error("busy/valid order"); // R8

    AST_ZERO_AVG_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (tte_valid && iavg == '0) |-> (tte == '1)) else $error("zero average not saturated"); // R6

    AST_AVG_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_stb) |-> $stable(iavg)) else $error("average moved without strobe"); // R3

endmodule

bind tte_avg_current tte_avg_current_chk #(.SMP_W(SMP_W), .TTE_W(TTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_stb   (smp_stb),
    .iavg_hi   (iavg_hi),
    .iavg_lo   (iavg_lo),
    .tte_hi    (tte_hi),
    .tte_lo    (tte_lo),
    .tte_busy  (tte_busy),
    .tte_valid (tte_valid)
);

// File: tb/sim_tte_avg_current.sv
module sim_tte_avg_current;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_stb = 1'b0;
    logic signed [15:0] smp_cur = '0;
    logic [15:0]        cap_comp = '0;
    logic [7:0]         iavg_hi, iavg_lo, tte_hi, tte_lo;
    logic               tte_busy, tte_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #10 clk = ~clk;

    tte_avg_current u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_stb   (smp_stb),
        .smp_cur   (smp_cur),
        .cap_comp  (cap_comp),
        .iavg_hi   (iavg_hi),
        .iavg_lo   (iavg_lo),
        .tte_hi    (tte_hi),
        .tte_lo    (tte_lo),
        .tte_busy  (tte_busy),
        .tte_valid (tte_valid)
    );

    // ---------------- behavioural reference ----------------
    longint m_sum = 0;
    int     m_n = 0;
    int     m_avg = 0;
    int     m_tte = 65535;
    bit     m_busy = 0;
    bit     m_valid = 0;
    bit     m_win = 0;
    int     m_pend = 0;
    int     m_pend_val = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_sum = 0; m_n = 0; m_avg = 0; m_tte = 65535;
            m_busy = 0; m_valid = 0; m_win = 0; m_pend = 0;
        end else begin
            bit idle_now;
            idle_now = (m_pend == 0);
            m_valid = 0;
            if (m_pend > 0) begin
                m_pend--;
                if (m_pend == 0) begin
                    m_tte = m_pend_val;
                    m_valid = 1;
                end
            end
            if (m_win && idle_now) begin
                longint q;
                if (m_avg == 0) begin
                    m_pend_val = 65535; m_pend = 1;
                end else begin
                    q = (64'(cap_comp) * 60) / m_avg;
                    if (q > 65535) begin
                        m_pend_val = 65535; m_pend = 1;
                    end else begin
                        m_pend_val = int'(q); m_pend = 18;
                    end
                end
            end
            m_win = 0;
            if (smp_stb) begin
                int v;
                v = int'(smp_cur);
                m_sum += (v < 0) ? -v : v;
                m_n++;
                if (m_n == 256) begin
                    m_avg = int'(m_sum / 256);
                    m_sum = 0; m_n = 0; m_win = 1;
                end
            end
            m_busy = (m_pend > 0);
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cyc > 0) begin
            chk("R2 R4 average vs model", {iavg_hi, iavg_lo}, m_avg);
            chk("R5 R9 R10 tte vs model", {tte_hi, tte_lo}, m_tte);
            chk("R8 busy vs model", int'(tte_busy), int'(m_busy));
            chk("R8 R9 valid vs model", int'(tte_valid), int'(m_valid));
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    function automatic logic signed [15:0] sample(input int kind, input int i);
        case (kind)
            0: return 16'sd1000;
            1: return -16'sd2000;
            2: return (i % 2 == 0) ? 16'sd300 : -16'sd500;
            3: return 16'sd0;
            4: return -16'sd32768;
            5: return 16'sd60;
            6: return 16'sd59;
            7: return 16'sd1;
            default: return 16'(i);
        endcase
    endfunction

    task automatic run_window(input int kind, input int gap, input logic [15:0] cap,
                              input int exp_avg, input int exp_tte, input string tag);
        int prev_avg;
        prev_avg = {iavg_hi, iavg_lo};
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            smp_stb  = 1'b1;
            smp_cur  = sample(kind, i);
            cap_comp = cap;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                smp_stb = 1'b0;
                smp_cur = 16'sh7fff;
            end
            if (i == 128) chk("R3 average held mid-window", {iavg_hi, iavg_lo}, prev_avg);
        end
        @(negedge clk);
        smp_stb = 1'b0;
        smp_cur = -16'sd12345;
        repeat (25) @(negedge clk);
        chk({tag, " average"}, {iavg_hi, iavg_lo}, exp_avg);
        chk({tag, " tte"}, {tte_hi, tte_lo}, exp_tte);
        chk("R8 idle after result", int'(tte_busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset average", {iavg_hi, iavg_lo}, 0);
        chk("R1 reset tte", {tte_hi, tte_lo}, 16'hFFFF);
        chk("R1 reset busy", int'(tte_busy), 0);
        chk("R1 reset valid", int'(tte_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_window(0, 0, 16'd1000,  1000,  60,     "R2 R5 positive");
        run_window(1, 2, 16'd5000,  2000,  150,    "R2 R3 negative gapped");
        run_window(2, 0, 16'd60000, 400,   9000,   "R2 R5 alternating");
        run_window(3, 1, 16'd100,   0,     65535,  "R6 zero average");
        run_window(4, 0, 16'hFFFF,  32768, 119,    "R2 R4 most negative");
        run_window(5, 0, 16'hFFFF,  60,    65535,  "R5 exact limit");
        run_window(6, 0, 16'hFFFF,  59,    65535,  "R7 overflow");
        run_window(7, 0, 16'd0,     1,     0,      "R5 zero capacity");
        run_window(8, 1, 16'd1234,  127,   582,    "R2 R5 ramp truncation");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule